// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of a programmable interval timer. A counting-clock enable (`cnt_en`) advances it. Its behaviour comes from one of six operating modes: terminal-count signalling, gate-triggered one-shot, rate generation, square wave, software-triggered strobe and gate-triggered strobe. The mode, the BCD/binary choice and the initial count are all captured on one load strobe. The channel drives `out` and also presents its current count for the surrounding bus logic to read.

The gate input works in one of two ways, depending on the mode. In modes 0 and 4 it is a level that pauses counting. In modes 1, 2, 3 and 5 a rising edge restarts counting from the initial count, and in modes 2 and 3 a low gate also pauses counting. A loaded value of zero selects the largest count. In modes without reload, the counter wraps through its maximum value and keeps counting.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out` is 0 and `count_now` is 0. Until the first load strobe, the count does not change and `out` stays 0, whatever `cnt_en` and `gate` do.
- R2: A loaded value of 0 acts as 65536 in binary and as 10000 in BCD (`bcd_sel`=1, four BCD digits). Decrementing from 0 gives FFFF in binary and 9999 in BCD, and BCD decrements borrow decimally (0010 becomes 0009).
- R3: Mode 0 (`mode_sel`=0): in the cycle after a load, `count_now` equals the value and `out` is 0. Each tick decrements the count. `out` rises on the tick that brings the count to 0 and then stays high until the next load, while the count wraps and keeps going.
- R4: In modes 0 and 4 a low gate holds the count. A rising gate edge does not reload the count.
- R5: Mode 1: a load sets `out` to 1 and does not start counting. A rising gate edge sets the count to the initial value and `out` to 0. Ticks then decrement the count regardless of the gate level, and `out` returns to 1 on the tick that reaches 0. A further rising edge restarts counting.
- R6: Mode 2 with initial count N: the count runs N down to 1. On the tick taken at 1, the count reloads N and `out` is 1 for that one tick. Otherwise `out` is 0.
- R7: Mode 3 with initial count N: the count steps down by two, and `out` is high for (N+1)/2 ticks and low for the remaining N/2 ticks (rounded down) of each period. The count reloads N at each half-period.
- R8: Mode 4: after a load, `out` is 0 and goes to 1 for exactly one tick when the count first reaches 0.
- R9: Mode 5: a load leaves `out` 0. A rising gate edge loads the initial count, and `out` is 1 for one tick when the count reaches 0.
- R10: In modes 2 and 3 a low gate holds the count. A rising gate edge restarts from the initial count, and mode 3 restarts in its high half.
- R11: A load in mode 2 or 3 while that mode is already running changes only the initial count, which takes effect at the next reload.
- R12: `mode_sel` values 6 and 7 act as modes 2 and 3.
- R13: A load strobe takes priority over a tick in the same cycle, so the loaded value is not decremented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting-clock enable; one tick per cycle when high |
| gate | input | 1 | Gate: a level in modes 0 and 4, an edge trigger in modes 1, 2, 3 and 5 |
| load_val | input | CNT_W | Initial count to load |
| load_stb | input | 1 | Captures `load_val`, `mode_sel` and `bcd_sel` |
| mode_sel | input | 3 | Operating mode 0 to 7 |
| bcd_sel | input | 1 | 1 selects BCD counting |
| out | output | 1 | Channel output waveform |
| count_now | output | CNT_W | Live count for readout |

## Verification
Small counts (3, 4 and 5) are used in every mode, so that each expected waveform can be written out tick by tick. Odd and even values of N in mode 3 distinguish the asymmetric halves from the symmetric ones. Gate patterns are placed around the ticks to separate the modes that treat the gate as a level from those that treat it as an edge: holding the gate low, raising it without a tick, and raising it again while a count is running. A BCD zero load counted through all 10000 ticks, a binary wrap past zero, and a reload while a mode is running each check a different kind of boundary. In the reload case, the new count has to appear at the reload and not before it.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   typedef enum logic [2:0] {
      MD_TC_INT  = 3'd0,
      MD_ONESHOT = 3'd1,
      MD_RATE    = 3'd2,
      MD_SQUARE  = 3'd3,
      MD_SW_STB  = 3'd4,
      MD_HW_STB  = 3'd5
   } mode_t;
endpackage

// File: rtl/tmr_mode_map.sv
`timescale 1ns/1ps
module tmr_mode_map
   import tmr_pkg::*;
(
   input  logic [2:0] raw_mode,
   output mode_t      eff_mode
);
   // codes 6 and 7 fold onto the periodic modes
   always_comb begin
      if (raw_mode[2] && raw_mode[1])
         eff_mode = mode_t'({1'b0, raw_mode[1:0]});
      else
         eff_mode = mode_t'(raw_mode);
   end
endmodule

// File: rtl/tmr_gate_edge.sv
`timescale 1ns/1ps
module tmr_gate_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic rise
);
   logic gate_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate;
   end
   assign rise = gate && !gate_q;
endmodule

// File: rtl/tmr_step.sv
`timescale 1ns/1ps
module tmr_step #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [CNT_W-1:0] cur,
   input  logic [1:0]       amt,
   input  logic             bcd,
   output logic [CNT_W-1:0] nxt
);
   localparam int DIGITS = CNT_W / 4;

   logic [CNT_W-1:0] bin_res;
   assign bin_res = cur - CNT_W'(amt);

   generate
      if (BCD_EN) begin : g_bcd
         logic [CNT_W-1:0] bcd_res;
         always_comb begin
            logic [4:0] bw;
            logic [4:0] dg;
            bw      = {3'b000, amt};
            bcd_res = '0;
            for (int i = 0; i < DIGITS; i++) begin
               dg = {1'b0, cur[4*i +: 4]};
               if (dg >= bw) begin
                  bcd_res[4*i +: 4] = 4'(dg - bw);
                  bw = 5'd0;
               end else begin
                  bcd_res[4*i +: 4] = 4'(dg + 5'd10 - bw);
                  bw = 5'd1;
               end
            end
         end
         assign nxt = bcd ? bcd_res : bin_res;
      end else begin : g_bin
         logic unused_bcd;
         assign unused_bcd = bcd;
         assign nxt = bin_res;
      end
   endgenerate
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             gate,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_stb,
   input  logic [2:0]       mode_sel,
   input  logic             bcd_sel,
   output logic             out,
   output logic [CNT_W-1:0] count_now
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("tmr_channel: CNT_W must be at least 4");
      end
      if (BCD_EN && (CNT_W % 4 != 0)) begin : g_bad_bcd
         $error("tmr_channel: BCD counting needs CNT_W to be a multiple of 4");
      end
   endgenerate

   mode_t            ld_mode, cur_mode;
   logic             ld_bcd, cur_bcd;
   logic             armed, running, phase_hi, strobe_done, out_r;
   logic [CNT_W-1:0] init_val, cnt, dec;
   logic [1:0]       step_amt;
   logic             rise, trig, adv, fresh, sq_end;

   tmr_mode_map u_map (.raw_mode(mode_sel), .eff_mode(ld_mode));

   tmr_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise));

   tmr_step #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_step (
      .cur(cnt), .amt(step_amt), .bcd(cur_bcd), .nxt(dec)
   );

   assign ld_bcd = BCD_EN && bcd_sel;
   assign fresh  = !armed || (ld_mode != cur_mode) || (ld_bcd != cur_bcd);

   // square wave: an odd count is evened out by the first step of each half
   always_comb begin
      if (cur_mode == MD_SQUARE) begin
         if (cnt[0]) step_amt = phase_hi ? 2'd1 : 2'd3;
         else        step_amt = 2'd2;
      end else begin
         step_amt = 2'd1;
      end
   end

   assign sq_end = (cnt != '0) && (cnt <= CNT_W'(step_amt));

   assign trig = rise && armed &&
                 (cur_mode == MD_ONESHOT || cur_mode == MD_RATE ||
                  cur_mode == MD_SQUARE  || cur_mode == MD_HW_STB);

   assign adv = cnt_en && armed && running &&
                (gate || cur_mode == MD_ONESHOT || cur_mode == MD_HW_STB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed       <= 1'b0;
         cur_mode    <= MD_TC_INT;
         cur_bcd     <= 1'b0;
         init_val    <= '0;
         cnt         <= '0;
         out_r       <= 1'b0;
         running     <= 1'b0;
         phase_hi    <= 1'b0;
         strobe_done <= 1'b0;
      end else if (load_stb) begin
         armed    <= 1'b1;
         cur_mode <= ld_mode;
         cur_bcd  <= ld_bcd;
         init_val <= load_val;
         case (ld_mode)
            MD_TC_INT, MD_SW_STB: begin
               cnt         <= load_val;
               out_r       <= 1'b0;
               running     <= 1'b1;
               strobe_done <= 1'b0;
            end
            MD_ONESHOT: begin
               if (fresh) begin
                  out_r   <= 1'b1;
                  running <= 1'b0;
               end
            end
            MD_HW_STB: begin
               if (fresh) begin
                  out_r       <= 1'b0;
                  running     <= 1'b0;
                  strobe_done <= 1'b0;
               end
            end
            MD_RATE: begin
               if (fresh) begin
                  cnt     <= load_val;
                  out_r   <= 1'b0;
                  running <= 1'b1;
               end
            end
            default: begin
               if (fresh) begin
                  cnt      <= load_val;
                  out_r    <= 1'b1;
                  phase_hi <= 1'b1;
                  running  <= 1'b1;
               end
            end
         endcase
      end else if (trig) begin
         cnt         <= init_val;
         running     <= 1'b1;
         strobe_done <= 1'b0;
         phase_hi    <= 1'b1;
         out_r       <= (cur_mode == MD_SQUARE);
      end else if (adv) begin
         case (cur_mode)
            MD_TC_INT, MD_ONESHOT: begin
               cnt <= dec;
               if (dec == '0) out_r <= 1'b1;
            end
            MD_SW_STB, MD_HW_STB: begin
               cnt         <= dec;
               out_r       <= (dec == '0) && !strobe_done;
               strobe_done <= strobe_done || (dec == '0);
            end
            MD_RATE: begin
               if (cnt == ONE) begin
                  cnt   <= init_val;
                  out_r <= 1'b1;
               end else begin
                  cnt   <= dec;
                  out_r <= 1'b0;
               end
            end
            default: begin
               if (sq_end) begin
                  cnt      <= init_val;
                  phase_hi <= !phase_hi;
                  out_r    <= !phase_hi;
               end else begin
                  cnt <= dec;
               end
            end
         endcase
      end
   end

   assign out       = out_r;
   assign count_now = cnt;
endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_en,
   input logic             gate,
   input logic [CNT_W-1:0] load_val,
   input logic             load_stb,
   input logic [2:0]       mode_sel,
   input logic             out,
   input logic [CNT_W-1:0] count_now
);
   logic       seen_load, g_q;
   logic [2:0] ck_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_load <= 1'b0;
         g_q       <= 1'b0;
         ck_mode   <= 3'd0;
      end else begin
         g_q <= gate;
         if (load_stb) begin
            seen_load <= 1'b1;
            ck_mode   <= (mode_sel > 3'd5) ? mode_sel - 3'd4 : mode_sel;
         end
      end
   end

   // R1
   idle_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_load |-> (!out && count_now == '0));

   // R13
   count_moves_only_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load_stb && !(gate && !g_q)) |=> $stable(count_now));

   // R3
   level_mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && (mode_sel == 3'd0 || mode_sel == 3'd4))
      |=> (count_now == $past(load_val) && !out));

   // R6
   rate_pulse_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_mode == 3'd2 && out && cnt_en && gate && !load_stb && g_q &&
       count_now != CNT_W'(1)) |=> !out);

   // R3
   tc_out_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_load && ck_mode == 3'd0 && out && !load_stb) |=> out);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        gate = 1'b0;
   logic [15:0] load_val = '0;
   logic        load_stb = 1'b0;
   logic [2:0]  mode_sel = '0;
   logic        bcd_sel = 1'b0;
   logic        out;
   logic [15:0] count_now;

   int n_chk = 0;
   int n_bad = 0;

   tmr_channel dut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate),
      .load_val(load_val), .load_stb(load_stb), .mode_sel(mode_sel),
      .bcd_sel(bcd_sel), .out(out), .count_now(count_now)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] cnt_exp, input logic out_exp);
      n_chk++;
      if (count_now !== cnt_exp || out !== out_exp) begin
         n_bad++;
         $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                  req, count_now, out, cnt_exp, out_exp);
      end
   endtask

   task automatic chk_out(input string req, input logic out_exp);
      n_chk++;
      if (out !== out_exp) begin
         n_bad++;
         $display("FAIL %s: out=%b expected out=%b", req, out, out_exp);
      end
   endtask

   task automatic load(input logic [15:0] v, input logic [2:0] m, input logic b, input logic en);
      load_val = v; mode_sel = m; bcd_sel = b; load_stb = 1'b1; cnt_en = en;
      @(negedge clk);
      load_stb = 1'b0; cnt_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic set_gate(input logic g);
      gate = g;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 reset", 16'h0000, 1'b0);
      gate = 1'b1; ticks(5);
      chk("R1 no count before load", 16'h0000, 1'b0);
   endtask

   task automatic t_mode0;
      load(16'd5, 3'd0, 1'b0, 1'b0);
      chk("R3 load", 16'd5, 1'b0);
      ticks(4); chk("R3 before tc", 16'd1, 1'b0);
      ticks(1); chk("R3 at tc", 16'd0, 1'b1);
      ticks(1); chk("R2 binary wrap", 16'hFFFF, 1'b1);
   endtask

   task automatic t_gate_level;
      set_gate(1'b0);
      load(16'd10, 3'd0, 1'b0, 1'b0);
      ticks(3); chk("R4 gate low holds", 16'd10, 1'b0);
      set_gate(1'b1); chk("R4 rise no reload", 16'd10, 1'b0);
      ticks(2); chk("R4 resumes", 16'd8, 1'b0);
   endtask

   task automatic t_mode4;
      load(16'd3, 3'd4, 1'b0, 1'b0);
      ticks(2); chk("R8 before", 16'd1, 1'b0);
      ticks(1); chk("R8 strobe", 16'd0, 1'b1);
      ticks(1); chk("R8 strobe ends", 16'hFFFF, 1'b0);
   endtask

   task automatic t_mode1;
      set_gate(1'b0);
      load(16'd4, 3'd1, 1'b0, 1'b0);
      chk_out("R5 idle high", 1'b1);
      ticks(3); chk_out("R5 no start without edge", 1'b1);
      set_gate(1'b1); chk("R5 trigger", 16'd4, 1'b0);
      gate = 1'b0;
      ticks(3); chk("R5 counts with gate low", 16'd1, 1'b0);
      ticks(1); chk("R5 end", 16'd0, 1'b1);
      set_gate(1'b1); chk("R5 retrigger", 16'd4, 1'b0);
      ticks(2); chk("R5 running", 16'd2, 1'b0);
      set_gate(1'b0); set_gate(1'b1); chk("R5 retrigger mid count", 16'd4, 1'b0);
   endtask

   task automatic t_mode5;
      set_gate(1'b0);
      load(16'd3, 3'd5, 1'b0, 1'b0);
      chk_out("R9 idle low", 1'b0);
      set_gate(1'b1); chk("R9 trigger", 16'd3, 1'b0);
      ticks(2); chk("R9 before", 16'd1, 1'b0);
      ticks(1); chk("R9 strobe", 16'd0, 1'b1);
      ticks(1); chk("R9 strobe ends", 16'hFFFF, 1'b0);
   endtask

   task automatic t_mode2;
      set_gate(1'b1);
      load(16'd3, 3'd2, 1'b0, 1'b0);
      chk("R6 load", 16'd3, 1'b0);
      ticks(2); chk("R6 at one", 16'd1, 1'b0);
      ticks(1); chk("R6 pulse reload", 16'd3, 1'b1);
      ticks(1); chk("R6 pulse ends", 16'd2, 1'b0);
      load(16'd5, 3'd2, 1'b0, 1'b0);
      chk("R11 rate count kept", 16'd2, 1'b0);
      ticks(2); chk("R11 rate new count at reload", 16'd5, 1'b1);
      ticks(4); chk("R6 new period", 16'd1, 1'b0);
      ticks(1); chk("R6 new period pulse", 16'd5, 1'b1);
      ticks(1);
      set_gate(1'b0);
      ticks(2); chk("R10 rate gate low holds", 16'd4, 1'b0);
      set_gate(1'b1); chk("R10 rate restart", 16'd5, 1'b0);
   endtask

   task automatic t_mode3;
      load(16'd5, 3'd3, 1'b0, 1'b0);
      chk("R7 load", 16'd5, 1'b1);
      ticks(1); chk("R7 odd first step", 16'd4, 1'b1);
      ticks(1); chk("R7 step two", 16'd2, 1'b1);
      ticks(1); chk("R7 high half three ticks", 16'd5, 1'b0);
      ticks(1); chk("R7 low odd step", 16'd2, 1'b0);
      ticks(1); chk("R7 low half two ticks", 16'd5, 1'b1);
      load(16'd4, 3'd3, 1'b0, 1'b0);
      chk("R11 square count kept", 16'd5, 1'b1);
      ticks(3); chk("R11 square new count", 16'd4, 1'b0);
      ticks(2); chk("R7 even halves", 16'd4, 1'b1);
      ticks(1);
      set_gate(1'b0);
      ticks(2); chk("R10 square gate low holds", 16'd2, 1'b1);
      set_gate(1'b1); chk("R10 square restart", 16'd4, 1'b1);
   endtask

   task automatic t_alias;
      load(16'd3, 3'd6, 1'b0, 1'b0);
      chk("R12 six as rate", 16'd3, 1'b0);
      ticks(3); chk("R12 six pulse", 16'd3, 1'b1);
      load(16'd4, 3'd7, 1'b0, 1'b0);
      chk("R12 seven as square", 16'd4, 1'b1);
      ticks(2); chk("R12 seven half", 16'd4, 1'b0);
   endtask

   task automatic t_bcd;
      load(16'h0000, 3'd0, 1'b1, 1'b0);
      ticks(1); chk("R2 bcd zero first tick", 16'h9999, 1'b0);
      ticks(9998); chk("R2 bcd near end", 16'h0001, 1'b0);
      ticks(1); chk("R2 bcd 10000 ticks", 16'h0000, 1'b1);
      ticks(1); chk("R2 bcd wrap", 16'h9999, 1'b1);
      load(16'h0010, 3'd0, 1'b1, 1'b0);
      ticks(1); chk("R2 bcd borrow", 16'h0009, 1'b0);
   endtask

   task automatic t_load_prio;
      load(16'd7, 3'd0, 1'b0, 1'b1);
      chk("R13 load over tick", 16'd7, 1'b0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_mode0;
      t_gate_level;
      t_mode4;
      t_mode1;
      t_mode5;
      t_mode2;
      t_mode3;
      t_alias;
      t_bcd;
      t_load_prio;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule